// File: doc/BRIEF.md
# Floating-Point Error Interrupt Controller

This block turns the processor's legacy floating-point error indication into an interrupt request and a follow-up acknowledge. The processor drives an active-low fault line when an unmasked numeric error is pending. The block synchronizes that line into its own clock domain and raises a level-sensitive interrupt request toward the interrupt controller.

The error handler then writes to the dedicated error-clear port. That write strobe drops the interrupt and drives an active-low ignore-error signal back to the processor. The ignore signal is held only for as long as the fault line stays active. When the fault clears, the block returns to idle and can raise a new request.

A configuration enable gates the whole function. While the enable is low, both outputs sit at their inactive levels.

Top module: `cpe_irq_ctl`

## Requirements
- R1: After reset, `irq_o` is 0 and `ignore_n_o` is 1.
- R2: One clock edge after `enable_i` is sampled low, `irq_o` is 0 and `ignore_n_o` is 1, and they stay that way while the enable remains low, whatever `fault_n_i` and `clr_wr_i` do.
- R3: With the block enabled and idle, a low level on `fault_n_i` makes `irq_o` rise on the third rising clock edge after the input changes. This is two synchronizer stages plus one output register.
- R4: A `clr_wr_i` pulse sampled while `irq_o` is 1 and the synchronized fault is still active makes `irq_o` 0 and `ignore_n_o` 0 at the next edge.
- R5: While `ignore_n_o` is 0 and the synchronized fault stays active, `ignore_n_o` stays 0 and `irq_o` stays 0. Further writes have no effect.
- R6: After `fault_n_i` returns high, `ignore_n_o` returns to 1 on the third rising edge. `ignore_n_o` is 0 only if the synchronized fault was active at the previous edge.
- R7: A `clr_wr_i` pulse while the synchronized fault is inactive has no effect: `irq_o` stays 0 and `ignore_n_o` stays 1.
- R8: Once the ignore signal has been released, a new low level on `fault_n_i` raises `irq_o` again with the latency of R3.
- R9: If `fault_n_i` returns high before any write, `irq_o` falls on the third rising edge after the release.
- R10: `irq_o` = 1 and `ignore_n_o` = 0 never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Function enable from configuration space |
| fault_n_i | input | 1 | Floating-point fault from the processor, active low, asynchronous |
| clr_wr_i | input | 1 | One-cycle strobe for a write to the error-clear port |
| irq_o | output | 1 | Interrupt request level, active high |
| ignore_n_o | output | 1 | Ignore-error acknowledge to the processor, active low |

## Verification
Several properties are checked on every cycle against the synchronized fault level:
- the request and the acknowledge never overlap;
- the disable forces both outputs inactive;
- a write taken during a pending request swaps the request for the acknowledge;
- the acknowledge exists only while the synchronized fault is present.

The bench scenarios cover what depends on the asynchronous input's pin-to-output latency: the three-edge delay on assertion and release, re-arming after a completed handshake, and a fault withdrawn before it is serviced. A randomized run against a cycle model in the bench exercises interleavings of enable, fault and write that the directed cases do not reach.

// File: rtl/cpe_pkg.sv
package cpe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RAISED = 2'd1,
        ST_IGNORE = 2'd2
    } cpe_state_e;

    typedef struct packed {
        cpe_state_e state;
        logic       irq;
        logic       ign_n;
    } cpe_regs_t;

    localparam cpe_regs_t CPE_RESET = '{state: ST_IDLE, irq: 1'b0, ign_n: 1'b1};

endpackage

// File: rtl/cpe_sync.sv
module cpe_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d;
    logic [LAST:0] chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/cpe_fsm.sv
module cpe_fsm
    import cpe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic fault_i,
    input  logic wr_i,
    output logic irq_o,
    output logic ign_n_o
);
    cpe_regs_t r_d;
    cpe_regs_t r_q;

    always_comb begin
        r_d = r_q;
        if (!en_i) begin
            r_d.state = ST_IDLE;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (fault_i) r_d.state = ST_RAISED;
                end
                ST_RAISED: begin
                    if (!fault_i)  r_d.state = ST_IDLE;
                    else if (wr_i) r_d.state = ST_IGNORE;
                end
                ST_IGNORE: begin
                    if (!fault_i) r_d.state = ST_IDLE;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
        r_d.irq   = (r_d.state == ST_RAISED);
        r_d.ign_n = (r_d.state != ST_IGNORE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CPE_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq_o   = r_q.irq;
    assign ign_n_o = r_q.ign_n;
endmodule

// File: rtl/cpe_irq_ctl.sv
module cpe_irq_ctl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic fault_n_i,
    input  logic clr_wr_i,
    output logic irq_o,
    output logic ignore_n_o
);
    logic fault_n_s;
    logic fault_act;

    cpe_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (fault_n_i),
        .q_o   (fault_n_s)
    );

    assign fault_act = ~fault_n_s;

    cpe_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (enable_i),
        .fault_i (fault_act),
        .wr_i    (clr_wr_i),
        .irq_o   (irq_o),
        .ign_n_o (ignore_n_o)
    );
endmodule

// File: rtl/cpe_irq_chk.sv
module cpe_irq_chk (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic clr_wr_i,
    input logic fault_act,
    input logic irq_o,
    input logic ignore_n_o
);
    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && !ignore_n_o));

    assert_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!irq_o && ignore_n_o));

    assert_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && fault_act && ignore_n_o && !clr_wr_i) |=> irq_o);

    assert_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && fault_act && irq_o && clr_wr_i) |=> (!irq_o && !ignore_n_o));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && fault_act && !ignore_n_o) |=> !ignore_n_o);

    assert_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ignore_n_o |-> $past(fault_act));

    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !fault_act) |=> (!irq_o && ignore_n_o));
endmodule

bind cpe_irq_ctl cpe_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .clr_wr_i   (clr_wr_i),
    .fault_act  (fault_act),
    .irq_o      (irq_o),
    .ignore_n_o (ignore_n_o)
);

// File: tb/cpe_irq_ctl_bench.sv
module cpe_irq_ctl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b0;
    logic fault_n_i = 1'b1;
    logic clr_wr_i = 1'b0;
    logic irq_o;
    logic ignore_n_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cpe_irq_ctl u_cpe_irq_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .fault_n_i  (fault_n_i),
        .clr_wr_i   (clr_wr_i),
        .irq_o      (irq_o),
        .ignore_n_o (ignore_n_o)
    );

    // cycle model derived from the requirements: 0 idle, 1 request, 2 acknowledge
    logic m_p1 = 1'b0;
    logic m_p2 = 1'b0;
    int   m_st = 0;

    function automatic int model_next(int st, bit en, bit flt, bit wr);
        if (!en) return 0;
        if (st == 0) return flt ? 1 : 0;
        if (st == 1) return !flt ? 0 : (wr ? 2 : 1);
        return flt ? 2 : 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_p1 <= 1'b0;
            m_p2 <= 1'b0;
            m_st <= 0;
        end else begin
            m_p1 <= ~fault_n_i;
            m_p2 <= m_p1;
            m_st <= model_next(m_st, enable_i, m_p2, clr_wr_i);
        end
    end

    task automatic check(string tag, logic got_irq, logic got_ign_n,
                         logic exp_irq, logic exp_ign_n);
        total++;
        if (got_irq !== exp_irq || got_ign_n !== exp_ign_n) begin
            bad++;
            $display("FAIL %s: irq=%b ignore_n=%b expected irq=%b ignore_n=%b",
                     tag, got_irq, got_ign_n, exp_irq, exp_ign_n);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_wr();
        clr_wr_i = 1'b1;
        step(1);
        clr_wr_i = 1'b0;
    endtask

    initial begin
        step(3);
        check("R1 reset", irq_o, ignore_n_o, 1'b0, 1'b1);
        rst_n = 1'b1;
        step(1);
        check("R1 after release", irq_o, ignore_n_o, 1'b0, 1'b1);

        enable_i = 1'b1;
        step(1);
        pulse_wr();
        step(1);
        check("R7 write with no fault", irq_o, ignore_n_o, 1'b0, 1'b1);

        fault_n_i = 1'b0;
        step(2);
        check("R3 before latency", irq_o, ignore_n_o, 1'b0, 1'b1);
        step(1);
        check("R3 request raised", irq_o, ignore_n_o, 1'b1, 1'b1);

        pulse_wr();
        check("R4 swap on write", irq_o, ignore_n_o, 1'b0, 1'b0);
        pulse_wr();
        step(3);
        check("R5 acknowledge held", irq_o, ignore_n_o, 1'b0, 1'b0);

        fault_n_i = 1'b1;
        step(2);
        check("R6 before release latency", irq_o, ignore_n_o, 1'b0, 1'b0);
        step(1);
        check("R6 acknowledge released", irq_o, ignore_n_o, 1'b0, 1'b1);
        pulse_wr();
        step(2);
        check("R7 write after release", irq_o, ignore_n_o, 1'b0, 1'b1);

        fault_n_i = 1'b0;
        step(3);
        check("R8 request again", irq_o, ignore_n_o, 1'b1, 1'b1);

        fault_n_i = 1'b1;
        step(2);
        check("R9 before drop", irq_o, ignore_n_o, 1'b1, 1'b1);
        step(1);
        check("R9 request withdrawn", irq_o, ignore_n_o, 1'b0, 1'b1);

        fault_n_i = 1'b0;
        step(3);
        pulse_wr();
        check("R4 second swap", irq_o, ignore_n_o, 1'b0, 1'b0);
        enable_i = 1'b0;
        step(1);
        check("R2 disable clears", irq_o, ignore_n_o, 1'b0, 1'b1);
        pulse_wr();
        step(4);
        check("R2 stays off", irq_o, ignore_n_o, 1'b0, 1'b1);
        enable_i = 1'b1;
        step(1);
        check("R3 re-enable with fault held", irq_o, ignore_n_o, 1'b1, 1'b1);
        fault_n_i = 1'b1;
        step(4);

        // random phase compared against the bench model
        void'($urandom(32'h5eed_c0de));
        for (int c = 0; c < 3000; c++) begin
            enable_i  = ($urandom % 16) != 0;
            if (($urandom % 8) == 0) fault_n_i = ~fault_n_i;
            clr_wr_i  = ($urandom % 4) == 0;
            step(1);
            check("R10 model", irq_o, ignore_n_o,
                  (m_st == 1), (m_st != 2));
            if (irq_o === 1'b1 && ignore_n_o === 1'b0)
                check("R10 exclusive", irq_o, ignore_n_o, 1'b0, 1'b1);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule